// File: doc/BRIEF.md
# Serial Programming Instruction Receiver

This block is the target end of a four-byte serial command link used to load a device's non-volatile memory. A host drives a serial clock and a data line. The block samples the data line on each rising clock edge and assembles 32-bit instructions. It hands each finished instruction to a memory back end as an opcode, a 16-bit address and a data byte, together with a one-cycle strobe.

The data output does not carry read data. During each byte slot it shifts out the byte that came in during the slot before. A host that sends the programming-enable instruction can therefore check that its second byte comes back while it sends the third byte. If that byte does not come back, the host has lost byte framing. It then pulses the reset line, which clears the bit counter and the enable state, and tries again.

The serial clock, serial data and reset lines are asynchronous to the system clock. Each passes through a two-flop synchronizer, and serial clock edges are detected in the system clock domain.

Top module: `serprog_rx`

## Requirements
- R1: Bits are taken on rising serial clock edges, most significant bit first. In a decoded instruction the opcode is byte 0, the address is byte 1 (high) followed by byte 2 (low), and the data is byte 3.
- R2: `sdo_out` changes only after a falling serial clock edge or a framing reset. In every byte slot it shows the byte received in the previous slot, most significant bit first. It shows zero after reset.
- R3: While the third byte of the programming-enable instruction is being shifted, the value 0x53 received as its second byte appears on `sdo_out`.
- R4: An instruction is exactly 32 rising edges. `instr_valid` rises three system clock cycles after the 32nd rising edge is driven on `sck_in`, with no wait for a falling edge.
- R5: The programming-enable instruction has first byte 0xAC and second byte 0x53, and its last two bytes are ignored. While the block is not enabled, no other instruction asserts `instr_valid`. The enable instruction itself asserts it.
- R6: `prog_enabled` sets when a programming-enable instruction completes. It then stays set through all further instructions until a framing reset or a system reset.
- R7: A high pulse on `tgt_reset` of at least two system clock cycles clears the bit position, the echo byte, `sdo_out` and `prog_enabled`. Serial clock edges that arrive while the synchronized reset is high are ignored.
- R8: An asserted `rst_n` drives all outputs to zero at once, without waiting for a clock edge.
- R9: `instr_valid` is high for exactly one system clock cycle per accepted instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| tgt_reset | input | 1 | Active-high framing reset from the host, asynchronous |
| sck_in | input | 1 | Serial clock from the host, asynchronous |
| sdi_in | input | 1 | Serial data from the host |
| sdo_out | output | 1 | Serial data to the host (delayed echo) |
| instr_valid | output | 1 | One-cycle strobe for an accepted instruction |
| instr_op | output | 8 | Opcode byte of the last accepted instruction |
| instr_addr | output | 16 | Address bytes of the last accepted instruction |
| instr_data | output | 8 | Data byte of the last accepted instruction |
| prog_enabled | output | 1 | Programming mode has been entered |

## Verification
Each input change passes through two synchronizer flops and then one register stage, so its result lands three system clock cycles after it is driven. The bench drives inputs on falling system clock edges. It samples `instr_valid` and the decoded fields exactly three falling edges after the last rising serial clock edge, and one falling edge later it checks that the strobe has dropped. The bench holds each serial clock half-period for four system cycles. `sdo_out`, which updates three cycles after a falling serial edge, has therefore settled when the bench records it just before the next rising edge. The bench gives `tgt_reset` four cycles to clear the synchronizer before it checks the cleared state.

// File: rtl/serprog_pkg.sv
package serprog_pkg;
  localparam int BYTE_W       = 8;
  localparam int FRAME_BYTES  = 4;
  localparam int SYNC_STAGES  = 2;
  typedef logic [BYTE_W-1:0] byte_t;
  localparam byte_t ENABLE_OP = 8'hAC;
  localparam byte_t SYNC_BYTE = 8'h53;
endpackage

// File: rtl/serprog_sync.sv
module serprog_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/serprog_shift.sv
module serprog_shift #(
  parameter int NBYTES = 4,
  parameter int BYTE_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       sck_s,
  input  logic                       sdi_s,
  output logic                       sck_rise,
  output logic                       sck_fall,
  output logic                       byte_done,
  output logic [BYTE_W-1:0]          byte_val,
  output logic                       frame_done,
  output logic [NBYTES*BYTE_W-1:0]   frame_word
);
  localparam int FRAME_W   = NBYTES * BYTE_W;
  localparam int BIT_W     = $clog2(FRAME_W);
  localparam int BYTE_BITS = $clog2(BYTE_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_W - 1);

  logic               sck_q;
  logic [BIT_W-1:0]   bit_cnt_q, bit_cnt_d;
  logic [FRAME_W-1:0] sr_q, sr_d, sr_shift;
  logic               last_bit, byte_end;

  // edge detection against the previous synchronized level
  always_comb begin
    sck_rise = sck_s & ~sck_q & ~clr;
    sck_fall = ~sck_s & sck_q & ~clr;
  end

  always_comb begin
    sr_shift   = {sr_q[FRAME_W-2:0], sdi_s};
    last_bit   = (bit_cnt_q == LAST_BIT);
    byte_end   = (bit_cnt_q[BYTE_BITS-1:0] == {BYTE_BITS{1'b1}});
    byte_done  = sck_rise & byte_end;
    byte_val   = sr_shift[BYTE_W-1:0];
    frame_done = sck_rise & last_bit;
    frame_word = sr_shift;
  end

  // next state
  always_comb begin
    bit_cnt_d = bit_cnt_q;
    sr_d      = sr_q;
    if (clr) begin
      bit_cnt_d = '0;
      sr_d      = '0;
    end else if (sck_rise) begin
      sr_d      = sr_shift;
      bit_cnt_d = last_bit ? '0 : bit_cnt_q + BIT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q     <= 1'b0;
      bit_cnt_q <= '0;
      sr_q      <= '0;
    end else begin
      sck_q     <= sck_s;
      bit_cnt_q <= bit_cnt_d;
      sr_q      <= sr_d;
    end
  end
endmodule

// File: rtl/serprog_echo.sv
module serprog_echo #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] byte_val,
  input  logic              sck_fall,
  output logic              sdo
);
  logic [BYTE_W-1:0] echo_q, echo_d;
  logic              sdo_q, sdo_d;

  always_comb begin
    echo_d = echo_q;
    sdo_d  = sdo_q;
    if (clr) begin
      echo_d = '0;
      sdo_d  = 1'b0;
    end else if (byte_done) begin
      echo_d = byte_val;
    end else if (sck_fall) begin
      sdo_d  = echo_q[BYTE_W-1];
      echo_d = {echo_q[BYTE_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      echo_q <= '0;
      sdo_q  <= 1'b0;
    end else begin
      echo_q <= echo_d;
      sdo_q  <= sdo_d;
    end
  end

  assign sdo = sdo_q;
endmodule

// File: rtl/serprog_decode.sv
module serprog_decode
  import serprog_pkg::*;
#(
  parameter int NBYTES = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr,
  input  logic                         frame_done,
  input  logic [NBYTES*BYTE_W-1:0]     frame_word,
  output logic                         valid,
  output byte_t                        op,
  output logic [(NBYTES-2)*BYTE_W-1:0] addr,
  output byte_t                        data,
  output logic                         enabled
);
  localparam int FRAME_W = NBYTES * BYTE_W;
  localparam int ADDR_W  = (NBYTES - 2) * BYTE_W;

  logic               en_q, en_d, valid_q, valid_d;
  byte_t              op_q, op_d, data_q, data_d;
  logic [ADDR_W-1:0]  addr_q, addr_d;
  logic               is_enable, accept;

  always_comb begin
    is_enable = (frame_word[FRAME_W-1 -: BYTE_W] == ENABLE_OP) &&
                (frame_word[FRAME_W-BYTE_W-1 -: BYTE_W] == SYNC_BYTE);
    accept    = frame_done & (en_q | is_enable);
  end

  always_comb begin
    en_d    = en_q;
    valid_d = 1'b0;
    op_d    = op_q;
    addr_d  = addr_q;
    data_d  = data_q;
    if (clr) begin
      en_d = 1'b0;
    end else if (accept) begin
      en_d    = 1'b1;
      valid_d = 1'b1;
      op_d    = frame_word[FRAME_W-1 -: BYTE_W];
      addr_d  = frame_word[FRAME_W-BYTE_W-1 : BYTE_W];
      data_d  = frame_word[BYTE_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      valid_q <= 1'b0;
      op_q    <= '0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      en_q    <= en_d;
      valid_q <= valid_d;
      op_q    <= op_d;
      addr_q  <= addr_d;
      data_q  <= data_d;
    end
  end

  assign valid   = valid_q;
  assign op      = op_q;
  assign addr    = addr_q;
  assign data    = data_q;
  assign enabled = en_q;
endmodule

// File: rtl/serprog_rx.sv
module serprog_rx
  import serprog_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tgt_reset,
  input  logic        sck_in,
  input  logic        sdi_in,
  output logic        sdo_out,
  output logic        instr_valid,
  output logic [7:0]  instr_op,
  output logic [15:0] instr_addr,
  output logic [7:0]  instr_data,
  output logic        prog_enabled
);
  localparam int FRAME_W = FRAME_BYTES * BYTE_W;

  logic [2:0]         sync_q;
  logic               rst_s, sck_s, sdi_s;
  logic               sck_rise, sck_fall, byte_done, frame_done;
  logic [BYTE_W-1:0]  byte_val;
  logic [FRAME_W-1:0] frame_word;

  serprog_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({tgt_reset, sck_in, sdi_in}),
    .q     (sync_q)
  );

  assign rst_s = sync_q[2];
  assign sck_s = sync_q[1];
  assign sdi_s = sync_q[0];

  serprog_shift #(.NBYTES(FRAME_BYTES), .BYTE_W(BYTE_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (rst_s),
    .sck_s      (sck_s),
    .sdi_s      (sdi_s),
    .sck_rise   (sck_rise),
    .sck_fall   (sck_fall),
    .byte_done  (byte_done),
    .byte_val   (byte_val),
    .frame_done (frame_done),
    .frame_word (frame_word)
  );

  serprog_echo #(.BYTE_W(BYTE_W)) u_echo (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (rst_s),
    .byte_done (byte_done),
    .byte_val  (byte_val),
    .sck_fall  (sck_fall),
    .sdo       (sdo_out)
  );

  serprog_decode #(.NBYTES(FRAME_BYTES)) u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (rst_s),
    .frame_done (frame_done),
    .frame_word (frame_word),
    .valid      (instr_valid),
    .op         (instr_op),
    .addr       (instr_addr),
    .data       (instr_data),
    .enabled    (prog_enabled)
  );
endmodule

// File: rtl/serprog_rx_chk.sv
module serprog_rx_chk (
  input logic clk,
  input logic rst_n,
  input logic rst_s,
  input logic sck_rise,
  input logic sck_fall,
  input logic sdo_out,
  input logic instr_valid,
  input logic prog_enabled
);
  // R9: strobe lasts a single cycle
  a_r9_valid_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid |=> !instr_valid);

  // R5: a strobe only ever comes with programming mode active
  a_r5_valid_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid |-> prog_enabled);

  // R6: enable stays set unless a framing reset is seen
  a_r6_enable_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_enabled && !rst_s) |=> prog_enabled);

  // R7: framing reset clears the enable, the strobe and the output bit
  a_r7_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rst_s |=> (!prog_enabled && !instr_valid && !sdo_out));

  // R4: a strobe follows a detected rising serial edge
  a_r4_valid_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid |-> $past(sck_rise));

  // R2: the output bit moves only on a falling edge or a framing reset
  a_r2_sdo_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo_out) |-> ($past(sck_fall) || $past(rst_s)));
endmodule

bind serprog_rx serprog_rx_chk u_chk (.*);

// File: tb/serprog_rx_test.sv
module serprog_rx_test;
  logic        clk, rst_n, tgt_reset, sck_in, sdi_in;
  logic        sdo_out, instr_valid, prog_enabled;
  logic [7:0]  instr_op, instr_data;
  logic [15:0] instr_addr;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;
  logic       model_en;
  logic [7:0] prev_last;

  serprog_rx uut (
    .clk(clk), .rst_n(rst_n), .tgt_reset(tgt_reset), .sck_in(sck_in),
    .sdi_in(sdi_in), .sdo_out(sdo_out), .instr_valid(instr_valid),
    .instr_op(instr_op), .instr_addr(instr_addr), .instr_data(instr_data),
    .prog_enabled(prog_enabled)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  localparam int NVEC = 6;
  localparam logic [31:0] VEC_W [NVEC] = '{
    32'h2001_2300,   // not enabled: ignored
    32'hAC52_0000,   // wrong sync byte: no enable
    32'hAC53_0000,   // enable
    32'h4000_05A7,
    32'h2801_0200,
    32'hAC12_3456    // ordinary instruction once enabled
  };
  localparam logic VEC_V [NVEC] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1};

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_frame(input logic [31:0] w, input logic exp_v);
    logic [31:0] cap;
    logic        v1, v2, is_en;
    logic [7:0]  op_s, dat_s;
    logic [15:0] adr_s;
    cap = '0; v1 = 0; v2 = 0; op_s = '0; dat_s = '0; adr_s = '0;
    for (int i = 31; i >= 0; i--) begin
      sdi_in = w[i];
      repeat (4) @(negedge clk);
      cap[i] = sdo_out;
      sck_in = 1'b1;
      if (i == 0) begin
        repeat (3) @(negedge clk);
        v1 = instr_valid; op_s = instr_op; adr_s = instr_addr; dat_s = instr_data;
        @(negedge clk);
        v2 = instr_valid;
      end else begin
        repeat (4) @(negedge clk);
      end
      sck_in = 1'b0;
    end
    is_en = (w[31:16] == 16'hAC53);
    model_en = model_en | is_en;
    check(v1 == exp_v, "R4/R5 valid strobe", {31'd0, v1}, {31'd0, exp_v});
    check(v2 == 1'b0, "R9 strobe one cycle", {31'd0, v2}, 32'd0);
    if (exp_v) begin
      check({op_s, adr_s, dat_s} == w, "R1 decoded fields",
            {op_s, adr_s, dat_s}, w);
    end
    check(cap == {prev_last, w[31:8]}, "R2 delayed echo", cap, {prev_last, w[31:8]});
    if (is_en) check(cap[15:8] == 8'h53, "R3 sync echo", {24'd0, cap[15:8]}, 32'h53);
    check(prog_enabled == model_en, "R6 enable latch", {31'd0, prog_enabled},
          {31'd0, model_en});
    prev_last = w[7:0];
  endtask

  task automatic pulse_reset();
    tgt_reset = 1'b1;
    repeat (2) @(negedge clk);
    tgt_reset = 1'b0;
    repeat (4) @(negedge clk);
    model_en  = 1'b0;
    prev_last = 8'h00;
  endtask

  initial begin
    rst_n = 1'b0; tgt_reset = 1'b0; sck_in = 1'b0; sdi_in = 1'b0;
    model_en = 1'b0; prev_last = 8'h00;
    repeat (3) @(negedge clk);
    // R8: reset state while rst_n is low
    check({sdo_out, instr_valid, prog_enabled, instr_op, instr_addr, instr_data} == '0,
          "R8 reset outputs", {sdo_out, instr_valid, prog_enabled, 29'd0}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int k = 0; k < NVEC; k++) send_frame(VEC_W[k], VEC_V[k]);

    // R7: framing lost mid-instruction, recovered by a short reset pulse
    for (int i = 0; i < 13; i++) begin
      sdi_in = i[0];
      repeat (4) @(negedge clk); sck_in = 1'b1;
      repeat (4) @(negedge clk); sck_in = 1'b0;
    end
    pulse_reset();
    check(prog_enabled == 1'b0, "R7 enable cleared", {31'd0, prog_enabled}, 32'd0);
    check(sdo_out == 1'b0, "R7 echo cleared", {31'd0, sdo_out}, 32'd0);
    send_frame(32'h4000_0711, 1'b0);   // R5: ignored again after reset
    send_frame(32'hAC53_FFFF, 1'b1);   // R3 re-entry

    // R7: edges while reset is held are ignored
    tgt_reset = 1'b1;
    for (int i = 0; i < 8; i++) begin
      sdi_in = 1'b1;
      repeat (4) @(negedge clk); sck_in = 1'b1;
      repeat (4) @(negedge clk); sck_in = 1'b0;
    end
    tgt_reset = 1'b0;
    repeat (4) @(negedge clk);
    model_en = 1'b0; prev_last = 8'h00;
    send_frame(32'hAC53_1234, 1'b1);
    send_frame(32'hC1FF_EE01, 1'b1);

    // R8: asynchronous reset mid-run
    @(negedge clk);
    #3 rst_n = 1'b0;
    #1 check({instr_valid, prog_enabled, sdo_out} == 3'b000 && instr_op == 8'h00,
             "R8 async reset", {29'd0, instr_valid, prog_enabled, sdo_out}, 32'd0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule